// File: doc/BRIEF.md
# Instruction Control Decoder for a Fourteen-Instruction Load/Store Subset

This block turns the opcode and function fields of a 32-bit instruction into the control levels that a single-cycle datapath needs. These levels are the destination-register mux select, the jump and branch selects, the memory read and write strobes, the load-result mux select, the immediate-operand select and the register write strobe. It also produces a 3-bit ALU select. The block is purely combinational. Its outputs follow its two inputs within the same cycle, so the surrounding core samples them with its own clock.

The decode runs in two levels. A main decoder looks only at the opcode. It produces the datapath controls and a 3-bit intermediate ALU operation code. That code either names an ALU operation directly, or holds the value 7 to pass the choice to a second decoder that reads the function field. An encoding outside the supported set raises an illegal flag. When the flag is set, every control output, including all write strobes, is held at zero. The core can then stop without disturbing any architectural state.

Top module: `isa_ctrl_dec`

## Requirements
- R1: Opcode 0x00 with a supported function code gives reg_dst=1, reg_wr=1 and alu_op=7. jump, branch, mem_rd, mem_to_reg, mem_wr, alu_src and illegal are all 0.
- R2: Under opcode 0x00, these function codes map to these alu_sel values: 0x20 gives 0 (add), 0x22 gives 1 (subtract), 0x2A gives 2 (signed less-than), 0x2B gives 3 (unsigned less-than), 0x24 gives 4 (AND) and 0x25 gives 5 (OR).
- R3: For every legal opcode other than 0x00, alu_sel equals alu_op. The alu_op encoding is 0 add, 1 subtract, 2 signed less-than, 3 unsigned less-than, 4 AND, 5 OR and 6 shift left by 16.
- R4: Opcodes 0x08, 0x0A, 0x0B and 0x0F give alu_src=1, reg_wr=1 and reg_dst=0, with alu_op 0, 2, 3 and 6 respectively. No memory strobe, jump or branch is set.
- R5: Opcode 0x23 (word load) gives alu_src=1, mem_rd=1, mem_to_reg=1, reg_wr=1 and alu_op=0. All other controls are 0.
- R6: Opcode 0x2B (word store) gives alu_src=1, mem_wr=1 and alu_op=0, with reg_wr=0 and mem_rd=0.
- R7: Opcode 0x04 (branch on equal) gives branch=1 and alu_op=1, with alu_src=0 and no write or read strobe.
- R8: Opcode 0x02 (jump) gives jump=1 and alu_op=0, with every other control at 0.
- R9: Any opcode outside the set 0x00, 0x02, 0x04, 0x08, 0x0A, 0x0B, 0x0F, 0x23, 0x2B gives illegal=1. All controls are then 0, and alu_op and alu_sel are both 0.
- R10: Opcode 0x00 with a function code outside the R2 set gives illegal=1. All controls are then 0, and alu_op and alu_sel are both 0.
- R11: For any opcode other than 0x00, the function field has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 6 | Instruction opcode field |
| fn_i | input | 6 | Instruction function field |
| reg_dst_o | output | 1 | 1 selects the third register field as destination |
| jump_o | output | 1 | Selects the jump target |
| branch_o | output | 1 | Enables the equal-branch target |
| mem_rd_o | output | 1 | Data memory read strobe |
| mem_to_reg_o | output | 1 | Write-back takes memory data |
| mem_wr_o | output | 1 | Data memory write strobe |
| alu_src_o | output | 1 | Second ALU operand is the extended immediate |
| reg_wr_o | output | 1 | Register file write strobe |
| alu_op_o | output | 3 | Intermediate ALU operation code |
| alu_sel_o | output | 3 | Final ALU operation select |
| illegal_o | output | 1 | Unsupported encoding |

## Verification
The bench builds the decoder with its default field widths: a 6-bit opcode, a 6-bit function field and a 3-bit select. At those widths the whole 64-entry opcode space and the whole 64-entry function space under opcode 0x00 are small enough to sweep exhaustively. The sweep reaches every legal row and every illegal neighbour next to it. Seeded random pairs of opcode and function field then show that the function field has no effect when the opcode is not 0x00.

// File: rtl/isa_dec_pkg.sv
package isa_dec_pkg;

    localparam int OP_W  = 6;
    localparam int FN_W  = 6;
    localparam int SEL_W = 3;

    // opcode codes
    localparam logic [OP_W-1:0] OPC_REG   = 6'h00;
    localparam logic [OP_W-1:0] OPC_JMP   = 6'h02;
    localparam logic [OP_W-1:0] OPC_BEQ   = 6'h04;
    localparam logic [OP_W-1:0] OPC_ADDI  = 6'h08;
    localparam logic [OP_W-1:0] OPC_SLTI  = 6'h0A;
    localparam logic [OP_W-1:0] OPC_SLTIU = 6'h0B;
    localparam logic [OP_W-1:0] OPC_LUI   = 6'h0F;
    localparam logic [OP_W-1:0] OPC_LDW   = 6'h23;
    localparam logic [OP_W-1:0] OPC_STW   = 6'h2B;

    // function codes under OPC_REG
    localparam logic [FN_W-1:0] FNC_ADD  = 6'h20;
    localparam logic [FN_W-1:0] FNC_SUB  = 6'h22;
    localparam logic [FN_W-1:0] FNC_AND  = 6'h24;
    localparam logic [FN_W-1:0] FNC_OR   = 6'h25;
    localparam logic [FN_W-1:0] FNC_SLT  = 6'h2A;
    localparam logic [FN_W-1:0] FNC_SLTU = 6'h2B;

    // ALU operation encodings (shared by alu_op and alu_sel)
    localparam logic [SEL_W-1:0] AOP_ADD  = 3'd0;
    localparam logic [SEL_W-1:0] AOP_SUB  = 3'd1;
    localparam logic [SEL_W-1:0] AOP_SLT  = 3'd2;
    localparam logic [SEL_W-1:0] AOP_SLTU = 3'd3;
    localparam logic [SEL_W-1:0] AOP_AND  = 3'd4;
    localparam logic [SEL_W-1:0] AOP_OR   = 3'd5;
    localparam logic [SEL_W-1:0] AOP_SH16 = 3'd6;
    localparam logic [SEL_W-1:0] AOP_DEFER = 3'd7;

    typedef struct packed {
        logic reg_dst;
        logic jump;
        logic branch;
        logic mem_rd;
        logic mem_to_reg;
        logic mem_wr;
        logic alu_src;
        logic reg_wr;
    } ctrl_t;

    localparam ctrl_t CTRL_IDLE = '0;

endpackage

// File: rtl/isa_main_dec.sv
module isa_main_dec
    import isa_dec_pkg::*;
#(
    parameter int OPW = OP_W,
    parameter int SW  = SEL_W
) (
    input  logic [OPW-1:0] op_i,
    output ctrl_t          ctrl_o,
    output logic [SW-1:0]  aop_o,
    output logic           op_bad_o
);

    always_comb begin
        ctrl_o   = CTRL_IDLE;
        aop_o    = AOP_ADD;
        op_bad_o = 1'b0;
        unique case (op_i)
            OPC_REG: begin
                ctrl_o.reg_dst = 1'b1;
                ctrl_o.reg_wr  = 1'b1;
                aop_o          = AOP_DEFER;
            end
            OPC_JMP: begin
                ctrl_o.jump = 1'b1;
            end
            OPC_BEQ: begin
                ctrl_o.branch = 1'b1;
                aop_o         = AOP_SUB;
            end
            OPC_ADDI: begin
                ctrl_o.alu_src = 1'b1;
                ctrl_o.reg_wr  = 1'b1;
            end
            OPC_SLTI: begin
                ctrl_o.alu_src = 1'b1;
                ctrl_o.reg_wr  = 1'b1;
                aop_o          = AOP_SLT;
            end
            OPC_SLTIU: begin
                ctrl_o.alu_src = 1'b1;
                ctrl_o.reg_wr  = 1'b1;
                aop_o          = AOP_SLTU;
            end
            OPC_LUI: begin
                ctrl_o.alu_src = 1'b1;
                ctrl_o.reg_wr  = 1'b1;
                aop_o          = AOP_SH16;
            end
            OPC_LDW: begin
                ctrl_o.alu_src    = 1'b1;
                ctrl_o.mem_rd     = 1'b1;
                ctrl_o.mem_to_reg = 1'b1;
                ctrl_o.reg_wr     = 1'b1;
            end
            OPC_STW: begin
                ctrl_o.alu_src = 1'b1;
                ctrl_o.mem_wr  = 1'b1;
            end
            default: begin
                op_bad_o = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/isa_alu_dec.sv
module isa_alu_dec
    import isa_dec_pkg::*;
#(
    parameter int FW = FN_W,
    parameter int SW = SEL_W
) (
    input  logic [SW-1:0] aop_i,
    input  logic [FW-1:0] fn_i,
    output logic [SW-1:0] sel_o,
    output logic          fn_bad_o
);

    always_comb begin
        sel_o    = aop_i;
        fn_bad_o = 1'b0;
        if (aop_i == AOP_DEFER) begin
            unique case (fn_i)
                FNC_ADD:  sel_o = AOP_ADD;
                FNC_SUB:  sel_o = AOP_SUB;
                FNC_AND:  sel_o = AOP_AND;
                FNC_OR:   sel_o = AOP_OR;
                FNC_SLT:  sel_o = AOP_SLT;
                FNC_SLTU: sel_o = AOP_SLTU;
                default: begin
                    sel_o    = AOP_ADD;
                    fn_bad_o = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/isa_ctrl_dec.sv
module isa_ctrl_dec
    import isa_dec_pkg::*;
(
    input  logic [5:0] op_i,
    input  logic [5:0] fn_i,
    output logic       reg_dst_o,
    output logic       jump_o,
    output logic       branch_o,
    output logic       mem_rd_o,
    output logic       mem_to_reg_o,
    output logic       mem_wr_o,
    output logic       alu_src_o,
    output logic       reg_wr_o,
    output logic [2:0] alu_op_o,
    output logic [2:0] alu_sel_o,
    output logic       illegal_o
);

    ctrl_t             ctrl_raw;
    ctrl_t             ctrl_q;
    logic [SEL_W-1:0]  aop_raw;
    logic [SEL_W-1:0]  sel_raw;
    logic              op_bad;
    logic              fn_bad;
    logic              bad;

    isa_main_dec #(.OPW(OP_W), .SW(SEL_W)) main_i (
        .op_i     (op_i),
        .ctrl_o   (ctrl_raw),
        .aop_o    (aop_raw),
        .op_bad_o (op_bad)
    );

    isa_alu_dec #(.FW(FN_W), .SW(SEL_W)) alu_i (
        .aop_i    (aop_raw),
        .fn_i     (fn_i),
        .sel_o    (sel_raw),
        .fn_bad_o (fn_bad)
    );

    assign bad = op_bad | fn_bad;

    always_comb begin
        ctrl_q    = bad ? CTRL_IDLE : ctrl_raw;
        alu_op_o  = bad ? AOP_ADD : aop_raw;
        alu_sel_o = bad ? AOP_ADD : sel_raw;
        illegal_o = bad;
    end

    assign reg_dst_o    = ctrl_q.reg_dst;
    assign jump_o       = ctrl_q.jump;
    assign branch_o     = ctrl_q.branch;
    assign mem_rd_o     = ctrl_q.mem_rd;
    assign mem_to_reg_o = ctrl_q.mem_to_reg;
    assign mem_wr_o     = ctrl_q.mem_wr;
    assign alu_src_o    = ctrl_q.alu_src;
    assign reg_wr_o     = ctrl_q.reg_wr;

    always_comb begin
        if (!$isunknown({op_i, fn_i})) begin
            // R9
            illegal_quiet_chk: assert (!(illegal_o && (reg_wr_o || mem_wr_o || mem_rd_o)))
                else $error("strobe active on illegal encoding");
            // R10
            fn_bad_flag_chk: assert (!(fn_bad && !illegal_o))
                else $error("bad function code not flagged");
            // R3
            sel_follow_chk: assert (illegal_o || alu_op_o == AOP_DEFER || alu_sel_o == alu_op_o)
                else $error("alu_sel differs from alu_op");
            // R1
            defer_dst_chk: assert (alu_op_o != AOP_DEFER || (reg_dst_o && reg_wr_o))
                else $error("deferred op without rd write");
            // R5
            load_pair_chk: assert (mem_to_reg_o == mem_rd_o)
                else $error("load mux and read strobe disagree");
            // R8
            flow_excl_chk: assert (!(jump_o && branch_o) && !(mem_rd_o && mem_wr_o))
                else $error("exclusive controls both set");
        end
    end

endmodule

// File: tb/isa_ctrl_dec_tb_top.sv
`timescale 1ns/1ps
module isa_ctrl_dec_tb_top;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic [5:0] op, fn;
    logic reg_dst, jump, branch, mem_rd, mem_to_reg, mem_wr, alu_src, reg_wr, illegal;
    logic [2:0] alu_op, alu_sel;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    isa_ctrl_dec dut_i (
        .op_i(op), .fn_i(fn),
        .reg_dst_o(reg_dst), .jump_o(jump), .branch_o(branch),
        .mem_rd_o(mem_rd), .mem_to_reg_o(mem_to_reg), .mem_wr_o(mem_wr),
        .alu_src_o(alu_src), .reg_wr_o(reg_wr),
        .alu_op_o(alu_op), .alu_sel_o(alu_sel), .illegal_o(illegal)
    );

    // packed {illegal, reg_dst, jump, branch, mem_rd, mem_to_reg, mem_wr, alu_src, reg_wr, alu_op, alu_sel}
    function automatic logic [14:0] ref_vec(input logic [5:0] o, input logic [5:0] f);
        logic [8:0] c;
        logic [2:0] a, s;
        c = 9'b0; a = 3'd0; s = 3'd0;
        case (o)
            6'h00: begin
                case (f)
                    6'h20: s = 3'd0;
                    6'h22: s = 3'd1;
                    6'h2A: s = 3'd2;
                    6'h2B: s = 3'd3;
                    6'h24: s = 3'd4;
                    6'h25: s = 3'd5;
                    default: return {1'b1, 14'b0};
                endcase
                return {1'b0, 8'b1000_0001, 3'd7, s};
            end
            6'h02: begin c = 9'b0_0100_0000; a = 3'd0; end
            6'h04: begin c = 9'b0_0010_0000; a = 3'd1; end
            6'h08: begin c = 9'b0_0000_0011; a = 3'd0; end
            6'h0A: begin c = 9'b0_0000_0011; a = 3'd2; end
            6'h0B: begin c = 9'b0_0000_0011; a = 3'd3; end
            6'h0F: begin c = 9'b0_0000_0011; a = 3'd6; end
            6'h23: begin c = 9'b0_0001_1011; a = 3'd0; end
            6'h2B: begin c = 9'b0_0000_0110; a = 3'd0; end
            default: return {1'b1, 14'b0};
        endcase
        return {c, a, a};
    endfunction

    function automatic string tag_of(input logic [5:0] o, input logic [5:0] f);
        case (o)
            6'h00: begin
                if (ref_vec(o, f)[14]) return "R10";
                return "R1/R2";
            end
            6'h02: return "R8";
            6'h04: return "R7";
            6'h08, 6'h0A, 6'h0B, 6'h0F: return "R4/R3";
            6'h23: return "R5";
            6'h2B: return "R6";
            default: return "R9";
        endcase
    endfunction

    task automatic apply(input logic [5:0] o, input logic [5:0] f, input string tag);
        logic [14:0] act, exp;
        @(negedge clk);
        op = o; fn = f;
        #1;
        act = {illegal, reg_dst, jump, branch, mem_rd, mem_to_reg, mem_wr, alu_src, reg_wr, alu_op, alu_sel};
        exp = ref_vec(o, f);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s op=%h fn=%h actual=%b expected=%b", tag, o, f, act, exp);
        end
    endtask

    initial begin
        #40000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [5:0] ro, rf;
        logic [14:0] base;
        void'($urandom(32'd1234));
        op = 6'h00; fn = 6'h20;
        // directed corners
        apply(6'h00, 6'h20, "R1 add");
        apply(6'h00, 6'h22, "R2 sub");
        apply(6'h00, 6'h2B, "R2 sltu");
        apply(6'h00, 6'h27, "R10 nor unsupported");
        apply(6'h00, 6'h00, "R10 fn zero");
        apply(6'h23, 6'h3F, "R5 load");
        apply(6'h2B, 6'h00, "R6 store");
        apply(6'h04, 6'h11, "R7 beq");
        apply(6'h02, 6'h20, "R8 jump");
        apply(6'h0F, 6'h20, "R4 lui");
        apply(6'h03, 6'h20, "R9 neighbour");
        apply(6'h3F, 6'h3F, "R9 all ones");
        // exhaustive opcode sweep
        for (int i = 0; i < 64; i++) begin
            rf = 6'($urandom);
            apply(6'(i), rf, tag_of(6'(i), rf));
        end
        // exhaustive function sweep
        for (int i = 0; i < 64; i++) apply(6'h00, 6'(i), tag_of(6'h00, 6'(i)));
        // R11 random function fields on non-zero opcodes
        for (int i = 0; i < 600; i++) begin
            ro = 6'($urandom);
            if (ro == 6'h00) ro = 6'h23;
            rf = 6'($urandom);
            apply(ro, rf, "R11");
            base = ref_vec(ro, 6'h00);
            if (base !== ref_vec(ro, rf)) begin
                fails++;
                $display("FAIL R11 reference mismatch actual=%b expected=%b", ref_vec(ro, rf), base);
            end
        end
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule